// File: doc/BRIEF.md
# Two-Domain Power-Up Reset Sequencer

This block produces the two resets a clocked subsystem needs at power-up. The first goes to a clock synthesiser and the second goes to the logic it clocks. It runs from two clocks: a free-running reference clock and the synthesised output clock. After power-up it holds the synthesiser reset for a fixed count of reference-clock edges and then releases it for good. The system reset stays asserted until the synthesiser reports lock. It is released only after a further fixed count of output-clock edges during which lock holds and the reset button stays idle.

The lock status and the button are brought into the output-clock domain through two-flop synchronisers before use. A button press, or a loss of lock at any time, asserts the system reset again and clears the release count. The synthesiser reset is never touched again. The block has no reset input of its own: every flop starts from a declared initial value, so the reset state exists before the first clock edge.

Top module: `rstseq_top`

## Requirements
- R1: Before any clock edge, both outputs are high (asserted); both outputs are active-high.
- R2: `pll_rst_o` stays high for the first PLL_RESET_CLOCKS rising edges of `ref_clk` minus one, and goes low on rising edge number PLL_RESET_CLOCKS.
- R3: Once low, `pll_rst_o` stays low permanently, whatever `pll_locked_i` and `ext_rst_i` do.
- R4: `sys_rst_o` stays high while lock is absent; when `pll_locked_i` falls, `sys_rst_o` is high from the third `pll_clk` rising edge after the change (two synchroniser stages plus one register).
- R5: When `pll_locked_i` rises with the button idle, `sys_rst_o` goes low on the (2 + SOC_RESET_CLOCKS)-th `pll_clk` rising edge after the change.
- R6: With RESET_LOW = 1 the button is active when `ext_rst_i` is 0 (with RESET_LOW = 0, when it is 1); an active button asserts `sys_rst_o` from the third `pll_clk` rising edge after it becomes active.
- R7: When the button goes idle while locked, `sys_rst_o` goes low on the (2 + SOC_RESET_CLOCKS)-th `pll_clk` rising edge after the release.
- R8: A loss of lock during the release count restarts it: after lock returns, the full 2 + SOC_RESET_CLOCKS edges elapse again before `sys_rst_o` goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock |
| pll_clk | input | 1 | Synthesised output clock |
| pll_locked_i | input | 1 | Lock status from the synthesiser, asynchronous |
| ext_rst_i | input | 1 | Reset button, asynchronous, polarity set by RESET_LOW |
| pll_rst_o | output | 1 | Synthesiser reset, active-high, reference-clock domain |
| sys_rst_o | output | 1 | System reset, active-high, output-clock domain |

## Verification
A release counter that is not cleared by a hold shows up as a system reset that falls early, two or more edges ahead of its expected edge after lock returns. A stuck or wrongly initialised sequencer state shows up as a reset that never falls, or as one that is low before lock. A wrong power-up counter width or compare shows up as a synthesiser-reset release that is off by whole reference edges. A missing or extra synchroniser stage moves every system-reset change by one edge, so every edge-exact check sees it at the first lock or button event.

// File: rtl/rstseq_pkg.sv
// Package: shared constants and types for the reset sequencer.
// Assumes: a two-stage synchroniser is sufficient for the lock and button
// inputs at the output-clock rates this block targets.
package rstseq_pkg;

    // Number of flops in each clock-domain crossing synchroniser.
    localparam int unsigned SYNC_DEPTH = 2;

    // System-reset sequencer states.
    typedef enum logic [1:0] {
        SEQ_HOLD  = 2'd0,   // hold condition present, count cleared
        SEQ_COUNT = 2'd1,   // hold gone, counting towards release
        SEQ_RUN   = 2'd2    // system reset released
    } seq_state_t;

    // Counter width able to hold values 0 .. n-1 (at least one bit).
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
// Module: multi-stage flop synchroniser for a single asynchronous bit.
// Assumes: input changes are slow compared with the destination clock; the
// chain powers up at INIT so the output is defined before the first edge.
module rstseq_sync #(
    parameter int unsigned STAGES = 2,
    parameter bit          INIT   = 1'b0
) (
    input  logic clk,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q = {STAGES{INIT}};

    generate
        genvar s;
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the asynchronous input.
                always_ff @(posedge clk) begin
                    chain_q[0] <= d_i;
                end
            end else begin : g_next
                // Pass the value one stage along the chain.
                always_ff @(posedge clk) begin
                    chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rstseq_pll_hold.sv
// Module: power-up hold for the synthesiser reset in the reference domain.
// Assumes: no reset input; flops start at their declared values, so the
// output is high from time zero and falls once, on edge number CYCLES.
module rstseq_pll_hold #(
    parameter int unsigned CYCLES = 4
) (
    input  logic clk,
    output logic pll_rst_o
);

    import rstseq_pkg::*;

    localparam int unsigned     CW   = cnt_width(CYCLES);
    localparam logic [CW-1:0]   LAST = CW'(CYCLES - 1);

    logic [CW-1:0] edge_cnt_q = '0;
    logic          hold_q     = 1'b1;

    // Count reference edges while holding; drop the hold on the last one.
    always_ff @(posedge clk) begin
        if (hold_q) begin
            if (edge_cnt_q == LAST) begin
                hold_q <= 1'b0;
            end else begin
                edge_cnt_q <= edge_cnt_q + 1'b1;
            end
        end
    end

    assign pll_rst_o = hold_q;

endmodule

// File: rtl/rstseq_sys_hold.sv
// Module: system-reset sequencer in the output-clock domain.
// Assumes: hold_i is already synchronous to clk. Any cycle with hold_i high
// returns to SEQ_HOLD and clears the count; the reset is released on the
// CYCLES-th consecutive cycle without a hold.
module rstseq_sys_hold #(
    parameter int unsigned CYCLES = 4
) (
    input  logic clk,
    input  logic hold_i,
    output logic sys_rst_o
);

    import rstseq_pkg::*;

    localparam int unsigned     CW   = cnt_width(CYCLES);
    localparam logic [CW-1:0]   LAST = CW'(CYCLES - 1);

    seq_state_t    state_q   = SEQ_HOLD;
    seq_state_t    state_d;
    logic [CW-1:0] cnt_q     = '0;
    logic [CW-1:0] cnt_d;
    logic          rst_q     = 1'b1;

    // Next-state and count for the release sequence.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (hold_i) begin
            state_d = SEQ_HOLD;
            cnt_d   = '0;
        end else begin
            case (state_q)
                SEQ_HOLD, SEQ_COUNT: begin
                    if (cnt_q == LAST) begin
                        state_d = SEQ_RUN;
                    end else begin
                        state_d = SEQ_COUNT;
                        cnt_d   = cnt_q + 1'b1;
                    end
                end
                SEQ_RUN:  state_d = SEQ_RUN;
                default:  state_d = SEQ_HOLD;
            endcase
        end
    end

    // Register state, count and a glitch-free reset output.
    always_ff @(posedge clk) begin
        state_q <= state_d;
        cnt_q   <= cnt_d;
        rst_q   <= (state_d != SEQ_RUN);
    end

    assign sys_rst_o = rst_q;

endmodule

// File: rtl/rstseq_top.sv
// Module: two-domain reset sequencer top level.
// Assumes: ref_clk runs from power-up; pll_clk may be absent until lock.
// The block has no reset input: all state starts from flop initial values.
// The button polarity is fixed at build time by RESET_LOW.
module rstseq_top #(
    parameter int unsigned PLL_RESET_CLOCKS = 4,
    parameter int unsigned SOC_RESET_CLOCKS = 4,
    parameter bit          RESET_LOW        = 1'b1
) (
    input  logic ref_clk,
    input  logic pll_clk,
    input  logic pll_locked_i,
    input  logic ext_rst_i,
    output logic pll_rst_o,
    output logic sys_rst_o
);

    import rstseq_pkg::*;

    logic btn_active;
    logic btn_sync;
    logic lock_sync;
    logic sys_hold;

    // Map the button to an active-high request according to its polarity.
    generate
        if (RESET_LOW) begin : g_btn_low
            assign btn_active = ~ext_rst_i;
        end else begin : g_btn_high
            assign btn_active = ext_rst_i;
        end
    endgenerate

    rstseq_pll_hold #(
        .CYCLES (PLL_RESET_CLOCKS)
    ) u_pll_hold (
        .clk       (ref_clk),
        .pll_rst_o (pll_rst_o)
    );

    rstseq_sync #(
        .STAGES (SYNC_DEPTH),
        .INIT   (1'b0)
    ) u_lock_sync (
        .clk (pll_clk),
        .d_i (pll_locked_i),
        .q_o (lock_sync)
    );

    rstseq_sync #(
        .STAGES (SYNC_DEPTH),
        .INIT   (1'b1)
    ) u_btn_sync (
        .clk (pll_clk),
        .d_i (btn_active),
        .q_o (btn_sync)
    );

    assign sys_hold = ~lock_sync | btn_sync;

    rstseq_sys_hold #(
        .CYCLES (SOC_RESET_CLOCKS)
    ) u_sys_hold (
        .clk       (pll_clk),
        .hold_i    (sys_hold),
        .sys_rst_o (sys_rst_o)
    );

endmodule

// File: rtl/rstseq_chk.sv
// Module: assertion checker for rstseq_top, attached with bind below.
// Assumes: the synchroniser depth is two; windows longer than that are
// measured with local counters instead of deep $past.
module rstseq_chk #(
    parameter int unsigned PLL_RESET_CLOCKS = 4,
    parameter int unsigned SOC_RESET_CLOCKS = 4,
    parameter bit          RESET_LOW        = 1'b1
) (
    input logic ref_clk,
    input logic pll_clk,
    input logic pll_locked_i,
    input logic ext_rst_i,
    input logic pll_rst_o,
    input logic sys_rst_o
);

    localparam int unsigned REL_EDGES = 2 + SOC_RESET_CLOCKS;
    localparam int unsigned RW        = $clog2(REL_EDGES + 2);
    localparam int unsigned PW        = $clog2(PLL_RESET_CLOCKS + 2);

    logic          btn_on;
    logic [1:0]    pll_age    = '0;
    logic          ref_seen   = 1'b0;
    logic [PW-1:0] ref_edges  = '0;
    logic [RW-1:0] quiet_cnt  = '0;

    assign btn_on = RESET_LOW ? ~ext_rst_i : ext_rst_i;

    // Mark that the reference domain has seen an edge.
    always_ff @(posedge ref_clk) begin
        ref_seen <= 1'b1;
        if (ref_edges != PW'(PLL_RESET_CLOCKS + 1)) begin
            ref_edges <= ref_edges + 1'b1;
        end
    end

    // Age of the output-clock domain, saturating, and quiet-input count.
    always_ff @(posedge pll_clk) begin
        if (pll_age != 2'd3) begin
            pll_age <= pll_age + 1'b1;
        end
        if (!pll_locked_i || btn_on) begin
            quiet_cnt <= '0;
        end else if (quiet_cnt != RW'(REL_EDGES + 1)) begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    // R2
    pll_rst_hold_chk: assert property (@(posedge ref_clk) disable iff (!ref_seen)
        (ref_edges < PW'(PLL_RESET_CLOCKS)) |-> pll_rst_o);

    // R3
    pll_rst_once_chk: assert property (@(posedge ref_clk) disable iff (!ref_seen)
        !pll_rst_o |=> !pll_rst_o);

    // R4
    unlock_rst_chk: assert property (@(posedge pll_clk) disable iff (pll_age != 2'd3)
        (!pll_locked_i && $past(!pll_locked_i) && $past(!pll_locked_i, 2)) |=> sys_rst_o);

    // R6
    button_rst_chk: assert property (@(posedge pll_clk) disable iff (pll_age != 2'd3)
        (btn_on && $past(btn_on) && $past(btn_on, 2)) |=> sys_rst_o);

    // R5 R7 R8
    release_wait_chk: assert property (@(posedge pll_clk) disable iff (pll_age == 2'd0)
        $fell(sys_rst_o) |-> (quiet_cnt >= RW'(REL_EDGES)));

endmodule

bind rstseq_top rstseq_chk #(
    .PLL_RESET_CLOCKS (PLL_RESET_CLOCKS),
    .SOC_RESET_CLOCKS (SOC_RESET_CLOCKS),
    .RESET_LOW        (RESET_LOW)
) u_rstseq_chk (
    .ref_clk      (ref_clk),
    .pll_clk      (pll_clk),
    .pll_locked_i (pll_locked_i),
    .ext_rst_i    (ext_rst_i),
    .pll_rst_o    (pll_rst_o),
    .sys_rst_o    (sys_rst_o)
);

// File: tb/tb_rstseq_top.sv
// Bench: scoreboard of per-edge expectations for both reset outputs.
module tb_rstseq_top;

    typedef struct {
        int    cyc;
        bit    val;
        string req;
    } exp_t;

    logic ref_clk      = 1'b0;
    logic pll_clk      = 1'b0;
    logic pll_locked_i = 1'b0;
    logic ext_rst_i    = 1'b1;
    logic pll_rst_o;
    logic sys_rst_o;

    int   n_checks = 0;
    int   n_fails  = 0;
    int   pcyc     = 0;
    int   rcyc     = 0;
    bit   done     = 1'b0;
    exp_t sys_q[$];
    exp_t ref_q[$];

    rstseq_top #(
        .PLL_RESET_CLOCKS (4),
        .SOC_RESET_CLOCKS (4),
        .RESET_LOW        (1'b1)
    ) dut (
        .ref_clk      (ref_clk),
        .pll_clk      (pll_clk),
        .pll_locked_i (pll_locked_i),
        .ext_rst_i    (ext_rst_i),
        .pll_rst_o    (pll_rst_o),
        .sys_rst_o    (sys_rst_o)
    );

    // 250 MHz clocks; the output clock is offset by 1 ns.
    always #2 ref_clk = ~ref_clk;
    initial begin
        #1;
        forever #2 pll_clk = ~pll_clk;
    end

    always @(posedge ref_clk) rcyc <= rcyc + 1;
    always @(posedge pll_clk) pcyc <= pcyc + 1;

    task automatic check(input string req, input string what, input bit act, input bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // Driver side: queue expected system-reset values for edges lo..hi.
    task automatic push_sys(input int lo, input int hi, input bit v, input string req);
        for (int c = lo; c <= hi; c++) sys_q.push_back('{c, v, req});
    endtask

    task automatic push_ref(input int lo, input int hi, input bit v, input string req);
        for (int c = lo; c <= hi; c++) ref_q.push_back('{c, v, req});
    endtask

    task automatic until_p(input int c);
        while (pcyc < c) @(negedge pll_clk);
    endtask

    // Monitors: compare outputs against queue heads away from rising edges.
    always @(negedge pll_clk) begin
        while (sys_q.size() > 0 && sys_q[0].cyc <= pcyc) begin
            exp_t e;
            e = sys_q.pop_front();
            check(e.req, $sformatf("sys_rst_o after edge %0d", e.cyc), sys_rst_o, e.val);
        end
    end

    always @(negedge ref_clk) begin
        while (ref_q.size() > 0 && ref_q[0].cyc <= rcyc) begin
            exp_t e;
            e = ref_q.pop_front();
            check(e.req, $sformatf("pll_rst_o after edge %0d", e.cyc), pll_rst_o, e.val);
        end
    end

    initial begin
        // Reference domain: held for 3 edges, released on edge 4, never again.
        push_ref(1, 3, 1'b1, "R2");
        push_ref(4, 4, 1'b0, "R2");
        push_ref(5, 60, 1'b0, "R3");
        // Unlocked at power-up.
        push_sys(1, 10, 1'b1, "R4");
        // Lock at 10: release on edge 16.
        push_sys(11, 15, 1'b1, "R5");
        push_sys(16, 20, 1'b0, "R5");
        // Button active at 20: asserted from edge 23.
        push_sys(21, 22, 1'b0, "R6");
        push_sys(23, 26, 1'b1, "R6");
        // Button idle at 26: release on edge 32.
        push_sys(27, 31, 1'b1, "R7");
        push_sys(32, 36, 1'b0, "R7");
        // Lock lost at 36: asserted from edge 39.
        push_sys(37, 38, 1'b0, "R4");
        push_sys(39, 42, 1'b1, "R4");
        // Lock back at 42, lost at 44 mid-count, back at 50: release on 56.
        push_sys(43, 55, 1'b1, "R8");
        push_sys(56, 60, 1'b0, "R8");

        #1;
        check("R1", "pll_rst_o at power-up", pll_rst_o, 1'b1);
        check("R1", "sys_rst_o at power-up", sys_rst_o, 1'b1);

        until_p(10); pll_locked_i = 1'b1;
        until_p(20); ext_rst_i    = 1'b0;
        until_p(26); ext_rst_i    = 1'b1;
        until_p(36); pll_locked_i = 1'b0;
        until_p(42); pll_locked_i = 1'b1;
        until_p(44); pll_locked_i = 1'b0;
        until_p(50); pll_locked_i = 1'b1;
        until_p(62);
        while (sys_q.size() > 0 || ref_q.size() > 0) @(negedge pll_clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #20000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R5 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule